// File: doc/BRIEF.md
# AES Round-Key Schedule Generator

This block turns a 128-, 192- or 256-bit cipher key into the complete list of round-key words that an AES datapath consumes. After a one-cycle start pulse it writes one 32-bit word per clock into a word-addressed store: address 0 first, then each following address in turn, until the schedule for the selected key length is complete. A one-cycle done pulse follows the final write.

Each new word depends only on the word just produced and the word one key length earlier. The engine therefore keeps a short sliding history of the most recent words instead of the whole schedule. A single four-byte substitution unit serves both kinds of substituted word: the rotated word at the head of each group, and the extra unrotated step used in 256-bit mode. A key-size code that names no AES length is rejected with an error pulse, and nothing is written.

The store that receives the words, and any conversion of the schedule for decryption, sit outside this block.

Top module: `keyexp_engine`

## Requirements
- R1: While reset is held, and after it is released with no start, `wr_en`, `done` and `err` are all 0.
- R2: A start with `size_sel` 0 (128-bit), 1 (192-bit) or 2 (256-bit) produces exactly 44, 52 or 60 writes (4*(Nk+7), with Nk = 4, 6, 8). The writes fall in consecutive cycles, beginning in the cycle after the start, at addresses 0, 1, 2, and so on.
- R3: No write ever targets an address at or beyond the schedule length of the running key size. The last write of a run is at address length-1.
- R4: Word j for j < Nk equals key word j, where key word j is `key[255-32*j -: 32]` (word 0 in the top bits). A 128-bit key occupies `key[255:128]` and a 192-bit key occupies `key[255:64]`.
- R5: Word i with i >= Nk and i mod Nk = 0 is formed in three steps. First word i-1 is rotated left by one byte, so `{w[23:0],w[31:24]}`. Then every byte goes through the AES S-box. Finally the result is XORed with word i-Nk and with `{rc,24'h0}`. The constant rc is 01 for the first group and is multiplied by x in GF(2^8) (reduction 0x11B) for each later group.
- R6: Any other word with i >= Nk is word i-1 XOR word i-Nk, except as stated in R7.
- R7: With a 256-bit key, a word at group position 4 (i mod 8 = 4) is the S-box of each byte of word i-1, with no rotation, XORed with word i-8.
- R8: A start with `size_sel` 3 raises `err` for exactly one cycle, the cycle after the start. It causes no write and no `done`.
- R9: `done` is high for exactly one cycle, the cycle after the last write of a run.
- R10: A start that arrives while a run is in progress is ignored. The running schedule, its length and its latched key are unchanged, and no `err` is raised.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | One-cycle request to expand the key |
| size_sel | input | 2 | Key size: 0=128, 1=192, 2=256, 3=unsupported |
| key | input | 256 | Cipher key, word 0 in the top bits; sampled on an accepted start |
| wr_addr | output | 6 | Word address of the current write |
| wr_data | output | 32 | Round-key word being written |
| wr_en | output | 1 | Write strobe, one word per cycle |
| done | output | 1 | One-cycle pulse after the final write |
| err | output | 1 | One-cycle pulse for an unsupported key size |

## Verification
The bench builds the block with its default parameters: an eight-word history and a six-bit address. That is the only configuration AES needs, and with it every key length, every group position and the full 60-word address range can be reached. The bench builds its own S-box by brute-force search for inverses and recomputes each schedule in the textbook single-loop form. It sweeps many keys per size, including all-zero and all-ones keys, and checks three published schedule end words as fixed anchors. It also exercises the rejected size code and a second start issued in the middle of a run.

// File: rtl/keyexp_pkg.sv
package keyexp_pkg;

  localparam int WORD_W = 32;

  typedef enum logic [1:0] {
    KS_128 = 2'd0,
    KS_192 = 2'd1,
    KS_256 = 2'd2,
    KS_BAD = 2'd3
  } ksize_e;

  // Key length in words for a size code; 0 marks an unsupported code.
  function automatic int nk_of(input ksize_e s);
    case (s)
      KS_128:  return 4;
      KS_192:  return 6;
      KS_256:  return 8;
      default: return 0;
    endcase
  endfunction

  function automatic logic [7:0] gf_xtime(input logic [7:0] b);
    return {b[6:0], 1'b0} ^ (b[7] ? 8'h1b : 8'h00);
  endfunction

  function automatic logic [7:0] gf_mul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] acc;
    logic [7:0] sh;
    acc = 8'h00;
    sh  = a;
    for (int k = 0; k < 8; k++) begin
      if (b[k]) acc = acc ^ sh;
      sh = gf_xtime(sh);
    end
    return acc;
  endfunction

  // Multiplicative inverse as x^254; maps 0 to 0.
  function automatic logic [7:0] gf_inv(input logic [7:0] x);
    logic [7:0] r;
    logic [7:0] p;
    r = 8'h01;
    p = x;
    for (int k = 0; k < 7; k++) begin
      p = gf_mul(p, p);
      r = gf_mul(r, p);
    end
    return r;
  endfunction

  function automatic logic [7:0] rotl8(input logic [7:0] v, input int n);
    return 8'((v << n) | (v >> (8 - n)));
  endfunction

  function automatic logic [7:0] sbox_fwd(input logic [7:0] x);
    logic [7:0] v;
    v = gf_inv(x);
    return v ^ rotl8(v, 1) ^ rotl8(v, 2) ^ rotl8(v, 3) ^ rotl8(v, 4) ^ 8'h63;
  endfunction

  function automatic logic [WORD_W-1:0] rot_word(input logic [WORD_W-1:0] w);
    return {w[WORD_W-9:0], w[WORD_W-1 -: 8]};
  endfunction

endpackage

// File: rtl/keyexp_subword.sv
module keyexp_subword
  import keyexp_pkg::*;
#(
  parameter int LANES = 4
) (
  input  logic [8*LANES-1:0] din,
  output logic [8*LANES-1:0] dout
);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign dout[8*g +: 8] = sbox_fwd(din[8*g +: 8]);
  end

endmodule

// File: rtl/keyexp_seq.sv
module keyexp_seq
  import keyexp_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int NK_W   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              launch,
  input  logic [NK_W-1:0]   nk_in,
  output logic              active,
  output logic [ADDR_W-1:0] idx,
  output logic [NK_W-1:0]   pos,
  output logic [7:0]        rcon,
  output logic              done_p,
  output logic [NK_W-1:0]   nk
);

  logic [ADDR_W:0] total_w;
  logic            at_last;
  logic            past_key;

  assign total_w  = ((ADDR_W+1)'(nk) + (ADDR_W+1)'(7)) << 2;
  assign at_last  = ((ADDR_W+1)'(idx) + (ADDR_W+1)'(1)) == total_w;
  assign past_key = idx >= ADDR_W'(nk);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      idx    <= '0;
      pos    <= '0;
      rcon   <= 8'h01;
      done_p <= 1'b0;
      nk     <= '0;
    end else begin
      done_p <= 1'b0;
      if (launch && !active) begin
        active <= 1'b1;
        idx    <= '0;
        pos    <= '0;
        rcon   <= 8'h01;
        nk     <= nk_in;
      end else if (active) begin
        if (at_last) begin
          active <= 1'b0;
          done_p <= 1'b1;
        end
        idx <= idx + ADDR_W'(1);
        pos <= (pos == nk - NK_W'(1)) ? '0 : pos + NK_W'(1);
        if (past_key && pos == '0) rcon <= gf_xtime(rcon);
      end
    end
  end

endmodule

// File: rtl/keyexp_engine.sv
module keyexp_engine
  import keyexp_pkg::*;
#(
  parameter int MAX_NK = 8,
  parameter int ADDR_W = $clog2(4 * (MAX_NK + 7))
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     start,
  input  logic [1:0]               size_sel,
  input  logic [WORD_W*MAX_NK-1:0] key,
  output logic [ADDR_W-1:0]        wr_addr,
  output logic [WORD_W-1:0]        wr_data,
  output logic                     wr_en,
  output logic                     done,
  output logic                     err
);

  localparam int NK_W  = $clog2(MAX_NK + 1);
  localparam int HW    = $clog2(MAX_NK);
  localparam int KEY_W = WORD_W * MAX_NK;

  logic [KEY_W-1:0]  key_q;
  logic [WORD_W-1:0] hist  [MAX_NK];
  logic [WORD_W-1:0] key_w [MAX_NK];
  logic              active;
  logic [ADDR_W-1:0] idx;
  logic [NK_W-1:0]   pos;
  logic [7:0]        rcon;
  logic              done_p;
  logic [NK_W-1:0]   cur_nk;
  logic [NK_W-1:0]   sel_nk;
  logic              size_ok;
  logic              accept;
  logic              launch;
  logic              err_q;

  // Named internal events
  logic              ev_key_copy;
  logic              ev_grp_head;
  logic              ev_mid_sub;
  logic [HW-1:0]     far_sel;
  logic [WORD_W-1:0] far_word;
  logic [WORD_W-1:0] sub_in;
  logic [WORD_W-1:0] sub_out;
  logic [WORD_W-1:0] new_word;

  assign sel_nk  = NK_W'(nk_of(ksize_e'(size_sel)));
  assign size_ok = sel_nk != '0;
  assign accept  = start && !active;
  assign launch  = accept && size_ok;

  keyexp_seq #(.ADDR_W(ADDR_W), .NK_W(NK_W)) u_seq (
    .clk    (clk),
    .rst_n  (rst_n),
    .launch (launch),
    .nk_in  (sel_nk),
    .active (active),
    .idx    (idx),
    .pos    (pos),
    .rcon   (rcon),
    .done_p (done_p),
    .nk     (cur_nk)
  );

  for (genvar g = 0; g < MAX_NK; g++) begin : g_keyw
    assign key_w[g] = key_q[KEY_W-1-WORD_W*g -: WORD_W];
  end

  assign ev_key_copy = idx < ADDR_W'(cur_nk);
  assign ev_grp_head = !ev_key_copy && pos == '0;
  assign ev_mid_sub  = !ev_key_copy && cur_nk == NK_W'(8) && pos == NK_W'(4);
  assign far_sel     = HW'(cur_nk - NK_W'(1));
  assign far_word    = hist[far_sel];
  assign sub_in      = ev_grp_head ? rot_word(hist[0]) : hist[0];

  keyexp_subword #(.LANES(WORD_W / 8)) u_sub (
    .din  (sub_in),
    .dout (sub_out)
  );

  always_comb begin
    if (ev_key_copy)      new_word = key_w[idx[HW-1:0]];
    else if (ev_grp_head) new_word = sub_out ^ far_word ^ {rcon, 24'h000000};
    else if (ev_mid_sub)  new_word = sub_out ^ far_word;
    else                  new_word = hist[0] ^ far_word;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      key_q <= '0;
      err_q <= 1'b0;
      for (int k = 0; k < MAX_NK; k++) hist[k] <= '0;
    end else begin
      err_q <= accept && !size_ok;
      if (launch) key_q <= key;
      if (active) begin
        hist[0] <= new_word;
        for (int k = 1; k < MAX_NK; k++) hist[k] <= hist[k-1];
      end
    end
  end

  assign wr_en   = active;
  assign wr_addr = idx;
  assign wr_data = new_word;
  assign done    = done_p;
  assign err     = err_q;

endmodule

// File: rtl/keyexp_engine_chk.sv
module keyexp_engine_chk #(
  parameter int ADDR_W = 6,
  parameter int NK_W   = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic              done,
  input logic              err,
  input logic [NK_W-1:0]   cur_nk
);

  logic [ADDR_W:0] lim;
  assign lim = ((ADDR_W+1)'(cur_nk) + (ADDR_W+1)'(7)) * (ADDR_W+1)'(4);

  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> ((ADDR_W+1)'(wr_addr) < lim));

  p_last_addr_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wr_en) |-> ((ADDR_W+1)'($past(wr_addr)) == lim - (ADDR_W+1)'(1)));

  p_first_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wr_en) |-> (wr_addr == '0));

  p_addr_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && $past(wr_en)) |-> (wr_addr == $past(wr_addr) + ADDR_W'(1)));

  p_done_after_last_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($past(wr_en) && !wr_en));

  p_err_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> (!wr_en && !done));

endmodule

bind keyexp_engine keyexp_engine_chk #(.ADDR_W(ADDR_W), .NK_W(NK_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .wr_en   (wr_en),
  .wr_addr (wr_addr),
  .done    (done),
  .err     (err),
  .cur_nk  (cur_nk)
);

// File: tb/keyexp_engine_bench.sv
module keyexp_engine_bench;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         start;
  logic [1:0]   size_sel;
  logic [255:0] key;
  logic [5:0]   wr_addr;
  logic [31:0]  wr_data;
  logic         wr_en;
  logic         done;
  logic         err;

  always #5 clk = ~clk;

  keyexp_engine u_keyexp_engine (
    .clk(clk), .rst_n(rst_n), .start(start), .size_sel(size_sel), .key(key),
    .wr_addr(wr_addr), .wr_data(wr_data), .wr_en(wr_en), .done(done), .err(err)
  );

  int total_checks = 0;
  int bad_checks   = 0;
  int cyc = 0;

  // Monitor state (written only by the monitor)
  logic [31:0] cap [64];
  int nwr = 0, order_bad = 0, done_cnt = 0, err_cnt = 0;
  int first_cyc = 0, last_cyc = 0, done_cyc = 0, err_cyc = 0, last_addr = 0;
  bit was_wr = 1'b0;
  int next_addr = 0;

  logic [7:0] sbt [256];

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (wr_en) begin
      if (!was_wr) begin
        first_cyc = cyc;
        next_addr = 0;
      end
      if (int'(wr_addr) != next_addr) order_bad++;
      next_addr = int'(wr_addr) + 1;
      cap[wr_addr] = wr_data;
      nwr++;
      last_cyc  = cyc;
      last_addr = int'(wr_addr);
    end
    was_wr = wr_en;
    if (done) begin done_cnt++; done_cyc = cyc; end
    if (err)  begin err_cnt++;  err_cyc  = cyc; end
  end

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint got, input longint expv);
    total_checks++;
    if (!ok) begin
      bad_checks++;
      $display("FAIL %s %s: got %0h exp %0h", tag, what, got, expv);
    end
  endtask

  function automatic logic [7:0] b_xt(input logic [7:0] b);
    return b[7] ? ({b[6:0], 1'b0} ^ 8'h1b) : {b[6:0], 1'b0};
  endfunction

  function automatic logic [7:0] b_mul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] r = 8'h00;
    logic [7:0] x = a;
    logic [7:0] y = b;
    while (y != 0) begin
      if (y[0]) r ^= x;
      x = b_xt(x);
      y = y >> 1;
    end
    return r;
  endfunction

  function automatic logic [31:0] b_sub(input logic [31:0] w);
    return {sbt[w[31:24]], sbt[w[23:16]], sbt[w[15:8]], sbt[w[7:0]]};
  endfunction

  task automatic build_sbox();
    logic [7:0] c = 8'h63;
    for (int x = 0; x < 256; x++) begin
      logic [7:0] inv = 8'h00;
      logic [7:0] o;
      for (int y = 1; y < 256; y++)
        if (b_mul(8'(x), 8'(y)) == 8'h01) inv = 8'(y);
      for (int i = 0; i < 8; i++)
        o[i] = inv[i] ^ inv[(i+4)%8] ^ inv[(i+5)%8] ^ inv[(i+6)%8] ^ inv[(i+7)%8] ^ c[i];
      sbt[x] = o;
    end
  endtask

  task automatic expand(input logic [255:0] k, input int nk, output logic [31:0] ex [60]);
    int tot = 4 * (nk + 7);
    for (int i = 0; i < 60; i++) ex[i] = 32'h0;
    for (int i = 0; i < tot; i++) begin
      if (i < nk) ex[i] = k[255-32*i -: 32];
      else begin
        logic [31:0] t = ex[i-1];
        if (i % nk == 0) begin
          logic [7:0] rc = 8'h01;
          for (int g = 1; g < i / nk; g++) rc = b_xt(rc);
          t = b_sub({t[23:0], t[31:24]}) ^ {rc, 24'h0};
        end else if (nk > 6 && i % nk == 4) begin
          t = b_sub(t);
        end
        ex[i] = ex[i-nk] ^ t;
      end
    end
  endtask

  task automatic run(input logic [1:0] sz, input logic [255:0] k, input bit poke);
    int n0 = nwr, d0 = done_cnt, e0 = err_cnt, o0 = order_bad;
    int sc, nk, tot;
    logic [31:0] ex [60];
    @(negedge clk);
    size_sel = sz; key = k; start = 1'b1; sc = cyc;
    @(negedge clk);
    start = 1'b0;
    if (poke) begin
      repeat (10) @(negedge clk);
      start = 1'b1; size_sel = 2'd3; key = ~k;
      @(negedge clk);
      start = 1'b1; size_sel = 2'd0;
      @(negedge clk);
      start = 1'b0; size_sel = sz; key = k;
    end
    repeat (75) @(negedge clk);
    if (sz == 2'd3) begin
      chk(err_cnt - e0 == 1, "R8", "err pulses", err_cnt - e0, 1);
      chk(err_cyc == sc + 1, "R8", "err cycle", err_cyc, sc + 1);
      chk(nwr - n0 == 0, "R8", "writes", nwr - n0, 0);
      chk(done_cnt - d0 == 0, "R8", "done pulses", done_cnt - d0, 0);
    end else begin
      nk  = 4 + 2 * int'(sz);
      tot = 4 * (nk + 7);
      expand(k, nk, ex);
      chk(nwr - n0 == tot, "R2", "write count", nwr - n0, tot);
      chk(first_cyc == sc + 1, "R2", "first write cycle", first_cyc, sc + 1);
      chk(order_bad == o0, "R2", "address order", order_bad - o0, 0);
      chk(last_addr == tot - 1, "R3", "last address", last_addr, tot - 1);
      chk(done_cnt - d0 == 1, "R9", "done pulses", done_cnt - d0, 1);
      chk(done_cyc == last_cyc + 1, "R9", "done cycle", done_cyc, last_cyc + 1);
      if (poke) chk(err_cnt - e0 == 0, "R10", "err on busy start", err_cnt - e0, 0);
      for (int i = 0; i < tot; i++) begin
        string tg;
        if (i < nk)               tg = "R4";
        else if (i % nk == 0)     tg = "R5";
        else if (nk == 8 && i % nk == 4) tg = "R7";
        else                      tg = "R6";
        if (poke) tg = {tg, "/R10"};
        chk(cap[i] == ex[i], tg, $sformatf("word %0d", i), cap[i], ex[i]);
      end
    end
  endtask

  function automatic logic [255:0] mk_key(input int n);
    logic [255:0] k;
    if (n == 0) return '0;
    if (n == 1) return '1;
    for (int j = 0; j < 8; j++)
      k[255-32*j -: 32] = 32'((n * 8 + j + 1) * 32'h9E3779B9) ^ 32'(n << (j * 3));
    return k;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    total_checks++;
    bad_checks++;
    $display("FAIL watchdog: got timeout exp completion");
    $display("test done: total=%0d bad=%0d", total_checks, bad_checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; start = 1'b0; size_sel = 2'd0; key = '0;
    build_sbox();
    repeat (3) @(negedge clk);
    chk(!wr_en && !done && !err, "R1", "outputs in reset", {wr_en, done, err}, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(!wr_en && !done && !err, "R1", "outputs idle", {wr_en, done, err}, 0);

    // Published anchors
    run(2'd0, {128'h2b7e151628aed2a6abf7158809cf4f3c, 128'h0}, 1'b0);
    chk(cap[43] == 32'hb6630ca6, "R5", "128-bit anchor w43", cap[43], 32'hb6630ca6);
    run(2'd1, {192'h8e73b0f7da0e6452c810f32b809079e562f8ead2522c6b7b, 64'h0}, 1'b0);
    chk(cap[51] == 32'h01002202, "R5", "192-bit anchor w51", cap[51], 32'h01002202);
    run(2'd2, 256'h603deb1015ca71be2b73aef0857d77811f352c073b6108d72d9810a30914dff4, 1'b0);
    chk(cap[59] == 32'h706c631e, "R7", "256-bit anchor w59", cap[59], 32'h706c631e);

    for (int s = 0; s < 3; s++)
      for (int n = 0; n < 6; n++)
        run(2'(s), mk_key(n), 1'b0);

    run(2'd3, mk_key(4), 1'b0);
    run(2'd3, '1, 1'b0);

    run(2'd1, mk_key(7), 1'b1);
    run(2'd2, mk_key(9), 1'b1);

    $display("test done: total=%0d bad=%0d", total_checks, bad_checks);
    $finish;
  end

endmodule